// File: doc/BRIEF.md
# Full-Bridge Motor Drive Controller

This block is the digital core of a motor full bridge. The bridge has two high-side switches and two external low-side transistors. Two direction inputs and two enable lines pick one of several modes: drive in either direction, brake to supply, brake to ground, standby, or a single half-bridge on its own. A PWM input modulates only the low-side gates. Before any low-side gate may turn on, the block waits out a programmable dead time.

Each half-bridge has its own fault latch. The latch is set by overtemperature on that high side or by saturation of that low-side transistor. While latched, the half-bridge is held off and its open-drain pull-down request is asserted, so the shared enable line also serves as a fault flag. A low-to-high transition on that half's direction input releases the latch.

An undervoltage flag switches every output off without latching. A test mode drives the high sides from the direction inputs with both gate drivers disabled, and reports a disconnected load on the diagnostic pull-down. All asynchronous inputs pass through a two-stage synchroniser, and every output is registered.

Top module: `hbridge_ctrl`

## Requirements
- R1: With both enables at 1 and both direction inputs at 1, both high sides are on and both low-side gates are off.
- R2: With both enables at 1, dir_a=1 and dir_b=0 give hs_a=1 and ls_b=1 with hs_b=0 and ls_a=0. The mirror input gives the mirror output.
- R3: With both enables at 1 and both direction inputs at 0, both low-side gates are on and both high sides are off.
- R4: With both enables at 0, every high-side and gate output is 0 whatever the direction inputs are.
- R5: With only one enable at 1, only that half-bridge operates: direction 1 turns on its high side, direction 0 turns on its gate. The other half-bridge stays entirely off.
- R6: A high side and the low-side gate of the same half-bridge are never 1 in the same cycle.
- R7: pwm=0 forces both gate outputs to 0 and leaves the high sides unchanged. When pwm returns to 1, the gates resume the commanded state.
- R8: Overtemperature or saturation on a half-bridge latches a fault. The fault turns that half's outputs off and sets its pull-down request pd_x=1. The other half-bridge is not affected.
- R9: A latched fault stays set after its flag clears. It is released only by a 0-to-1 transition of that half's direction input while the flag is low. A transition while the flag is still high does not release it.
- R10: uv=1 turns every high-side and gate output off without setting a fault. Normal operation returns when uv clears.
- R11: A gate output rises no sooner than DEAD_CYC cycles after its half-bridge starts commanding the low side.
- R12: With test_mode=1, both gates are 0 and the direction inputs drive the high sides. A high side that is on with its open_x flag at 1 asserts pd_x for as long as the flag stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a | input | 1 | Direction input, half-bridge A |
| dir_b | input | 1 | Direction input, half-bridge B |
| en_a | input | 1 | Sensed level of enable/diagnostic line A |
| en_b | input | 1 | Sensed level of enable/diagnostic line B |
| pwm | input | 1 | Low-side modulation gate, 0 forces gates off |
| test_mode | input | 1 | Load-continuity test mode |
| ot_a | input | 1 | Overtemperature flag, high side A |
| ot_b | input | 1 | Overtemperature flag, high side B |
| sat_a | input | 1 | Low-side saturation flag, half-bridge A |
| sat_b | input | 1 | Low-side saturation flag, half-bridge B |
| open_a | input | 1 | Load-disconnected flag seen while A is tested |
| open_b | input | 1 | Load-disconnected flag seen while B is tested |
| uv | input | 1 | Supply undervoltage flag |
| hs_a | output | 1 | High-side A on command |
| hs_b | output | 1 | High-side B on command |
| ls_a | output | 1 | Low-side gate A command |
| ls_b | output | 1 | Low-side gate B command |
| pd_a | output | 1 | Pull-down request for enable/diagnostic line A |
| pd_b | output | 1 | Pull-down request for enable/diagnostic line B |

## Verification
A latch release and a fresh fault can arrive in the same cycle. The bench provokes this by cycling dir_a from 0 to 1 while sat_a is still held high. It then expects the half-bridge to stay off with pd_a set, so the set must win over the release. Gate modulation and dead-time expiry can also coincide. The bench drops pwm while a dead-time count is running and checks that the gate comes up only once both conditions allow it, and that the high side of the other half-bridge is untouched.

// File: rtl/hbridge_pkg.sv
package hbridge_pkg;

    localparam int NUM_HALF = 2;

    // synchronised per-half-bridge view of the inputs
    typedef struct packed {
        logic dir;
        logic en;
        logic pwm;
        logic test;
        logic fault;
        logic open;
        logic uv;
    } hb_in_t;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hb_half.sv
module hb_half
    import hbridge_pkg::*;
#(
    parameter int DEAD_CYC = 50000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  hb_in_t in_s,
    output logic   hs,
    output logic   ls,
    output logic   pd
);

    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] DEAD_V = CW'(DEAD_CYC);

    typedef struct packed {
        logic          flt;
        logic          dir_prev;
        logic [CW-1:0] cnt;
        logic          hs;
        logic          ls;
        logic          pd;
    } half_st_t;

    half_st_t st_d, st_q;
    logic     rise, live, hs_want, ls_want;

    always_comb begin
        st_d          = st_q;
        rise          = in_s.dir & ~st_q.dir_prev;
        st_d.dir_prev = in_s.dir;

        // a present fault wins over a release edge
        if (in_s.fault)  st_d.flt = 1'b1;
        else if (rise)   st_d.flt = 1'b0;

        live    = in_s.en & ~st_q.flt & ~in_s.fault & ~in_s.uv;
        hs_want = live & in_s.dir;
        ls_want = live & ~in_s.dir & ~in_s.test;

        if (!ls_want)             st_d.cnt = '0;
        else if (st_q.cnt != DEAD_V) st_d.cnt = st_q.cnt + 1'b1;

        st_d.hs = hs_want;
        st_d.ls = ls_want & in_s.pwm & (st_q.cnt == DEAD_V);
        st_d.pd = st_d.flt | (in_s.test & hs_want & in_s.open);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs = st_q.hs;
    assign ls = st_q.ls;
    assign pd = st_q.pd;

    a_r6_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.hs && st_q.ls));

    a_r7_pwm_gates_low: assert property (@(posedge clk) disable iff (!rst_n)
        !in_s.pwm |=> !st_q.ls);

    a_r8_fault_off_flag: assert property (@(posedge clk) disable iff (!rst_n)
        in_s.fault |=> (st_q.pd && !st_q.hs && !st_q.ls));

    a_r9_release_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flt) |-> st_q.dir_prev);

    a_r10_uv_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        in_s.uv |=> (!st_q.hs && !st_q.ls));

    a_r11_dead_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ls) |-> (st_q.cnt == DEAD_V));

    a_r12_test_no_gate: assert property (@(posedge clk) disable iff (!rst_n)
        in_s.test |=> !st_q.ls);

endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hbridge_pkg::*;
#(
    parameter int DEAD_CYC    = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_a,
    input  logic dir_b,
    input  logic en_a,
    input  logic en_b,
    input  logic pwm,
    input  logic test_mode,
    input  logic ot_a,
    input  logic ot_b,
    input  logic sat_a,
    input  logic sat_b,
    input  logic open_a,
    input  logic open_b,
    input  logic uv,
    output logic hs_a,
    output logic hs_b,
    output logic ls_a,
    output logic ls_b,
    output logic pd_a,
    output logic pd_b
);

    localparam int SW = 13;

    logic [SW-1:0]       raw, syn;
    logic [NUM_HALF-1:0] dir_v, en_v, fault_v, open_v, hs_v, ls_v, pd_v;
    logic                pwm_s, test_s, uv_s;

    assign raw = {dir_b, dir_a, en_b, en_a, ot_b | sat_b, ot_a | sat_a,
                  open_b, open_a, pwm, test_mode, uv, 2'b00};

    hb_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw),
        .q    (syn)
    );

    assign dir_v   = syn[12:11];
    assign en_v    = syn[10:9];
    assign fault_v = syn[8:7];
    assign open_v  = syn[6:5];
    assign pwm_s   = syn[4];
    assign test_s  = syn[3];
    assign uv_s    = syn[2];

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        hb_in_t hin;
        always_comb begin
            hin.dir   = dir_v[h];
            hin.en    = en_v[h];
            hin.pwm   = pwm_s;
            hin.test  = test_s;
            hin.fault = fault_v[h];
            hin.open  = open_v[h];
            hin.uv    = uv_s;
        end
        hb_half #(.DEAD_CYC(DEAD_CYC)) i_half (
            .clk  (clk),
            .rst_n(rst_n),
            .in_s (hin),
            .hs   (hs_v[h]),
            .ls   (ls_v[h]),
            .pd   (pd_v[h])
        );
    end

    assign hs_a = hs_v[0];
    assign hs_b = hs_v[1];
    assign ls_a = ls_v[0];
    assign ls_b = ls_v[1];
    assign pd_a = pd_v[0];
    assign pd_b = pd_v[1];

    a_r4_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_v[0] && !en_v[1]) |=> (hs_v == '0 && ls_v == '0));

endmodule

// File: tb/test_hbridge_ctrl.sv
module test_hbridge_ctrl;

    localparam int DEAD = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_a = 0, dir_b = 0, en_a = 0, en_b = 0, pwm = 1, test_mode = 0;
    logic ot_a = 0, ot_b = 0, sat_a = 0, sat_b = 0, open_a = 0, open_b = 0, uv = 0;
    logic hs_a, hs_b, ls_a, ls_b, pd_a, pd_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hbridge_ctrl #(.DEAD_CYC(DEAD)) i_hbridge_ctrl (
        .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b),
        .en_a(en_a), .en_b(en_b), .pwm(pwm), .test_mode(test_mode),
        .ot_a(ot_a), .ot_b(ot_b), .sat_a(sat_a), .sat_b(sat_b),
        .open_a(open_a), .open_b(open_b), .uv(uv),
        .hs_a(hs_a), .hs_b(hs_b), .ls_a(ls_a), .ls_b(ls_b),
        .pd_a(pd_a), .pd_b(pd_b)
    );

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // expected vector order: {hs_a, hs_b, ls_a, ls_b, pd_a, pd_b}
    task automatic chk(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {hs_a, hs_b, ls_a, ls_b, pd_a, pd_b};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic t_reset;
        chk("R4 reset", 6'b000000);
    endtask

    task automatic t_brake_vcc;
        en_a = 1; en_b = 1; dir_a = 1; dir_b = 1;
        settle(30);
        chk("R1 brake to supply", 6'b110000);
    endtask

    task automatic t_drive;
        dir_a = 1; dir_b = 0;
        settle(30);
        chk("R2 clockwise", 6'b100100);
        dir_a = 0; dir_b = 1;
        settle(30);
        chk("R2 counter-clockwise", 6'b011000);
    endtask

    task automatic t_brake_gnd;
        dir_a = 0; dir_b = 0;
        settle(30);
        chk("R3 brake to ground", 6'b001100);
    endtask

    task automatic t_standby;
        en_a = 0; en_b = 0; dir_a = 1; dir_b = 0;
        settle(30);
        chk("R4 standby 1/0", 6'b000000);
        dir_a = 0; dir_b = 0;
        settle(30);
        chk("R4 standby 0/0", 6'b000000);
    endtask

    task automatic t_single;
        en_a = 1; en_b = 0; dir_a = 1; dir_b = 1;
        settle(30);
        chk("R5 only A high side", 6'b100000);
        dir_a = 0; dir_b = 0;
        settle(30);
        chk("R5 only A gate", 6'b001000);
        en_a = 0; en_b = 1; dir_b = 1;
        settle(30);
        chk("R5 only B high side", 6'b010000);
    endtask

    task automatic t_dead;
        en_a = 1; en_b = 1; dir_a = 1; dir_b = 1;
        settle(30);
        dir_b = 0;
        settle(12);
        chk("R11 gate held during dead time, R6 high side off", 6'b100000);
        settle(18);
        chk("R11 gate on after dead time", 6'b100100);
    endtask

    task automatic t_pwm;
        pwm = 0;
        settle(6);
        chk("R7 pwm low gates off, high side kept", 6'b100000);
        pwm = 1;
        settle(6);
        chk("R7 pwm high restores gate", 6'b100100);
        // pwm low during a running dead-time count
        dir_b = 1;
        settle(6);
        dir_b = 0; pwm = 0;
        settle(30);
        chk("R7 pwm low over dead-time expiry", 6'b100000);
        pwm = 1;
        settle(6);
        chk("R7 gate after pwm and dead time", 6'b100100);
    endtask

    task automatic t_fault;
        ot_a = 1;
        settle(6);
        ot_a = 0;
        settle(10);
        chk("R8 fault latched on A, B unaffected", 6'b000110);
        settle(20);
        chk("R9 latch held after flag clears", 6'b000110);
        dir_a = 0;
        settle(6);
        chk("R9 falling input does not release", 6'b000110);
        sat_a = 1;
        dir_a = 1;
        settle(8);
        chk("R9 rising edge with flag still set keeps latch", 6'b000110);
        sat_a = 0;
        settle(8);
        chk("R9 still latched after saturation clears", 6'b000110);
        dir_a = 0;
        settle(6);
        dir_a = 1;
        settle(8);
        chk("R9 release on rising edge", 6'b100100);
    endtask

    task automatic t_uv;
        uv = 1;
        settle(6);
        chk("R10 undervoltage all off", 6'b000000);
        uv = 0;
        settle(6);
        chk("R10 high side back, gate in dead time", 6'b100000);
        settle(25);
        chk("R10 full resume, no latch", 6'b100100);
    endtask

    task automatic t_test;
        test_mode = 1; dir_a = 1; dir_b = 0;
        settle(6);
        chk("R12 test mode drives A, gates off", 6'b100000);
        open_a = 1;
        settle(6);
        chk("R12 open load flagged on A", 6'b100010);
        open_a = 0;
        settle(6);
        chk("R12 flag follows open load", 6'b100000);
        dir_a = 0; dir_b = 1;
        settle(30);
        chk("R12 test mode drives B, no gate on A", 6'b010000);
        test_mode = 0;
    endtask

    initial begin
        settle(3);
        t_reset();
        rst_n = 1'b1;
        settle(5);
        t_reset();
        t_brake_vcc();
        t_drive();
        t_brake_gnd();
        t_standby();
        t_single();
        t_dead();
        t_pwm();
        t_fault();
        t_uv();
        t_test();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule